// File: doc/BRIEF.md
# PHY Trim Parameter Programming Sequencer

This block loads a short table of analog trim settings into a PHY once the PHY is out of reset. The PHY can only be reached through a narrow indirect test port. The sequencer drives a write-only command word that carries a write strobe, a register address and a data byte, and it reads back a data byte from the PHY. Each table entry names one 8-bit PHY register, a bit field inside it (upper and lower bit position) and a value. The sequencer reads the register and merges the shifted value into the read-back byte, so bits outside the field keep their contents. It then writes the merged byte with a low-high-low strobe and finishes with a closing read.

The port needs settling time after each change of the command word. Every new word is therefore followed by a fixed number of read-back sample cycles, two by default, before the word may change again. A pulse on `start` runs the whole table in index order. `done` then rises and stays high until the next `start`. A legacy mode and an empty table finish at once and leave the port untouched. A malformed table raises `cfg_err` and is not programmed at all.

Top module: `trim_prog_seq`

## Requirements
- R1: The command word is `{data[7:0], addr[4:0], we}`. The write strobe is bit 0, the address is bits 5:1 and the data byte is bits 13:6.
- R2: After any new command word the block asserts `test_sample` for at least two consecutive cycles. The word does not change while `test_sample` is high.
- R3: Each entry starts with a fetch: the entry's address, data 1, strobe low, two settling samples, then one capture of `test_rdata`.
- R4: Next comes the write: the merged byte with the strobe low, the same word with the strobe high, then the same word with the strobe low again. Each of the three words is followed by its settling samples.
- R5: Each entry ends by presenting the fetch word again, with the settling samples and one further discarded sample.
- R6: The written byte equals `(readback & ~mask) | ((value << lsb) & mask)`, where the mask covers bits lsb..msb. PHY bits outside the field are preserved.
- R7: Entries 0 to `entry_count`-1 are processed in index order, each in 17 cycles. `done` rises 1 + 17·count cycles after the `start` edge.
- R8: When `legacy_mode` is set, or `entry_count` is 0, the port stays at all zeros with no samples, and `done` rises one cycle after `start`.
- R9: `done` holds until the next `start`, and `busy` is high while programming. When the block is not busy, the command word is all zeros and `test_sample` is low.
- R10: The block raises `cfg_err` and `done`, with no port activity, if `entry_count` exceeds 7, or if any entry below `entry_count` has msb > 7 or msb < lsb. Entries at or above `entry_count` are not checked.
- R11: After reset the command word is 0, and `test_sample`, `busy`, `done` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a programming run (accepted when idle or done) |
| legacy_mode | input | 1 | Skip all programming |
| entry_count | input | 4 | Number of valid table entries |
| tbl_adr | input | 35 | Per-entry PHY register address, 5 bits each, entry 0 lowest |
| tbl_msb | input | 28 | Per-entry field upper bit, 4 bits each |
| tbl_lsb | input | 28 | Per-entry field lower bit, 4 bits each |
| tbl_val | input | 56 | Per-entry value, 8 bits each, right-aligned |
| test_word | output | 14 | Command word to the PHY test port |
| test_rdata | input | 8 | Read-back byte from the PHY test port |
| test_sample | output | 1 | High in every cycle the read-back is sampled |
| busy | output | 1 | Programming in progress |
| done | output | 1 | Run finished |
| cfg_err | output | 1 | Last run rejected its configuration |

## Verification
A wrong phase or sample counter shows up at once at the port. A command word is repeated or skipped, or fewer than two `test_sample` cycles follow a new word, and the protocol monitor reports it in the same cycle. A wrong captured byte or mask stays silent until the write strobe. It then corrupts neighbouring bits of the modelled PHY register, and the bench reports that when the run ends, by comparing every model register with an arithmetically computed image. Errors in the index or in the end test change the recorded word list and the start-to-done cycle count, and both are checked after every run.

// File: rtl/trim_seq_pkg.sv
package trim_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_SET,
      ST_SMP,
      ST_CAP,
      ST_DONE
   } seq_state_t;

   typedef enum logic [2:0] {
      PH_FETCH,
      PH_STAGE,
      PH_STROBE,
      PH_RELEASE,
      PH_CONFIRM
   } seq_phase_t;

   function automatic seq_phase_t phase_after(seq_phase_t p);
      case (p)
         PH_FETCH:   return PH_STAGE;
         PH_STAGE:   return PH_STROBE;
         PH_STROBE:  return PH_RELEASE;
         PH_RELEASE: return PH_CONFIRM;
         default:    return PH_FETCH;
      endcase
   endfunction

   function automatic logic phase_reads(seq_phase_t p);
      return (p == PH_FETCH) || (p == PH_CONFIRM);
   endfunction

endpackage

// File: rtl/trim_cfg_check.sv
module trim_cfg_check #(
   parameter int MAX_ENTRIES = 7,
   parameter int CNT_W       = 4,
   parameter int POS_W       = 4,
   parameter int DAT_W       = 8
) (
   input  logic [CNT_W-1:0]             entry_count,
   input  logic [MAX_ENTRIES*POS_W-1:0] tbl_msb,
   input  logic [MAX_ENTRIES*POS_W-1:0] tbl_lsb,
   output logic                         cfg_bad
);

   localparam logic [POS_W-1:0] TOP_BIT = POS_W'(DAT_W - 1);

   logic [MAX_ENTRIES-1:0] ent_bad;
   logic                   count_bad;

   assign count_bad = entry_count > CNT_W'(MAX_ENTRIES);

   for (genvar i = 0; i < MAX_ENTRIES; i++) begin : g_ent
      logic [POS_W-1:0] hi;
      logic [POS_W-1:0] lo;
      assign hi = tbl_msb[i*POS_W +: POS_W];
      assign lo = tbl_lsb[i*POS_W +: POS_W];
      // only entries that will be used are judged
      assign ent_bad[i] = (entry_count > CNT_W'(i)) && ((hi > TOP_BIT) || (hi < lo));
   end

   assign cfg_bad = count_bad | (|ent_bad);

endmodule

// File: rtl/trim_entry_sel.sv
module trim_entry_sel #(
   parameter int MAX_ENTRIES    = 7,
   parameter int CNT_W          = 4,
   parameter int ADR_W          = 5,
   parameter int POS_W          = 4,
   parameter int DAT_W          = 8,
   parameter bit MERGE_READBACK = 1'b1
) (
   input  logic [CNT_W-1:0]             idx,
   input  logic [MAX_ENTRIES*ADR_W-1:0] tbl_adr,
   input  logic [MAX_ENTRIES*POS_W-1:0] tbl_msb,
   input  logic [MAX_ENTRIES*POS_W-1:0] tbl_lsb,
   input  logic [MAX_ENTRIES*DAT_W-1:0] tbl_val,
   input  logic [DAT_W-1:0]             readback,
   output logic [ADR_W-1:0]             sel_adr,
   output logic [DAT_W-1:0]             sel_mask,
   output logic [DAT_W-1:0]             wr_data
);

   logic [POS_W-1:0] sel_msb;
   logic [POS_W-1:0] sel_lsb;
   logic [DAT_W-1:0] sel_val;
   logic [DAT_W-1:0] field_bits;

   always_comb begin
      sel_adr = '0;
      sel_msb = '0;
      sel_lsb = '0;
      sel_val = '0;
      for (int i = 0; i < MAX_ENTRIES; i++) begin
         if (idx == CNT_W'(i)) begin
            sel_adr = tbl_adr[i*ADR_W +: ADR_W];
            sel_msb = tbl_msb[i*POS_W +: POS_W];
            sel_lsb = tbl_lsb[i*POS_W +: POS_W];
            sel_val = tbl_val[i*DAT_W +: DAT_W];
         end
      end
   end

   for (genvar b = 0; b < DAT_W; b++) begin : g_mask
      assign sel_mask[b] = (POS_W'(b) >= sel_lsb) && (POS_W'(b) <= sel_msb);
   end

   assign field_bits = (sel_val << sel_lsb) & sel_mask;

   if (MERGE_READBACK) begin : g_merge
      assign wr_data = (readback & ~sel_mask) | field_bits;
   end else begin : g_overwrite
      logic unused_readback;
      assign unused_readback = ^readback;
      assign wr_data = field_bits;
   end

endmodule

// File: rtl/trim_port_fsm.sv
module trim_port_fsm
   import trim_seq_pkg::*;
#(
   parameter int CNT_W       = 4,
   parameter int ADR_W       = 5,
   parameter int DAT_W       = 8,
   parameter int DUMMY_READS = 2,
   localparam int WORD_W     = DAT_W + ADR_W + 1,
   localparam int SMP_W      = (DUMMY_READS > 1) ? $clog2(DUMMY_READS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              legacy_mode,
   input  logic [CNT_W-1:0]  entry_count,
   input  logic              cfg_bad,
   input  logic [ADR_W-1:0]  sel_adr,
   input  logic [DAT_W-1:0]  wr_data,
   input  logic [DAT_W-1:0]  test_rdata,
   output logic [CNT_W-1:0]  idx,
   output logic [DAT_W-1:0]  cap_q,
   output logic [WORD_W-1:0] test_word,
   output logic              test_sample,
   output logic              busy,
   output logic              done,
   output logic              cfg_err
);

   localparam logic [SMP_W-1:0] LAST_SMP = SMP_W'(DUMMY_READS - 1);

   seq_state_t       state;
   seq_phase_t       phase;
   logic [SMP_W-1:0] smp_cnt;
   logic [CNT_W-1:0] last_idx;
   logic             on_port;

   assign last_idx = entry_count - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         phase   <= PH_FETCH;
         idx     <= '0;
         smp_cnt <= '0;
         cap_q   <= '0;
         cfg_err <= 1'b0;
      end else begin
         case (state)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  state   <= ST_CHECK;
                  cfg_err <= 1'b0;
               end
            end
            ST_CHECK: begin
               idx   <= '0;
               phase <= PH_FETCH;
               if (cfg_bad) begin
                  cfg_err <= 1'b1;
                  state   <= ST_DONE;
               end else if (legacy_mode || (entry_count == '0)) begin
                  state <= ST_DONE;
               end else begin
                  state <= ST_SET;
               end
            end
            ST_SET: begin
               smp_cnt <= '0;
               state   <= ST_SMP;
            end
            ST_SMP: begin
               if (smp_cnt == LAST_SMP) begin
                  if (phase_reads(phase)) begin
                     state <= ST_CAP;
                  end else begin
                     phase <= phase_after(phase);
                     state <= ST_SET;
                  end
               end else begin
                  smp_cnt <= smp_cnt + 1'b1;
               end
            end
            ST_CAP: begin
               if (phase == PH_FETCH) begin
                  cap_q <= test_rdata;
                  phase <= PH_STAGE;
                  state <= ST_SET;
               end else if (idx == last_idx) begin
                  state <= ST_DONE;
               end else begin
                  idx   <= idx + 1'b1;
                  phase <= PH_FETCH;
                  state <= ST_SET;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign on_port     = (state == ST_SET) || (state == ST_SMP) || (state == ST_CAP);
   assign test_sample = (state == ST_SMP) || (state == ST_CAP);
   assign busy        = (state != ST_IDLE) && (state != ST_DONE);
   assign done        = (state == ST_DONE);

   always_comb begin
      test_word = '0;
      if (on_port) begin
         if (phase_reads(phase))
            test_word = {DAT_W'(1), sel_adr, 1'b0};
         else
            test_word = {wr_data, sel_adr, phase == PH_STROBE};
      end
   end

   a_r2_hold_while_sampling: assert property (@(posedge clk) disable iff (!rst_n)
      test_sample |-> $stable(test_word));

   a_r2_present_then_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !test_sample && (test_word != '0)) |=> test_sample);

   a_r4_strobe_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(test_word[0]) |-> $past(test_sample));

   a_r8_skip_without_access: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CHECK && legacy_mode && !cfg_bad) |=> (done && test_word == '0));

   a_r10_error_blocks_port: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CHECK && cfg_bad) |=> (cfg_err && done && test_word == '0));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (test_word == '0 && !test_sample));

   a_r7_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      on_port |-> (idx < entry_count));

endmodule

// File: rtl/trim_prog_seq.sv
module trim_prog_seq #(
   parameter int MAX_ENTRIES    = 7,
   parameter int CNT_W          = 4,
   parameter int ADR_W          = 5,
   parameter int POS_W          = 4,
   parameter int DAT_W          = 8,
   parameter int DUMMY_READS    = 2,
   parameter bit MERGE_READBACK = 1'b1,
   localparam int WORD_W        = DAT_W + ADR_W + 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         legacy_mode,
   input  logic [CNT_W-1:0]             entry_count,
   input  logic [MAX_ENTRIES*ADR_W-1:0] tbl_adr,
   input  logic [MAX_ENTRIES*POS_W-1:0] tbl_msb,
   input  logic [MAX_ENTRIES*POS_W-1:0] tbl_lsb,
   input  logic [MAX_ENTRIES*DAT_W-1:0] tbl_val,
   output logic [WORD_W-1:0]            test_word,
   input  logic [DAT_W-1:0]             test_rdata,
   output logic                         test_sample,
   output logic                         busy,
   output logic                         done,
   output logic                         cfg_err
);

   if (MAX_ENTRIES < 1 || MAX_ENTRIES >= (1 << CNT_W)) begin : g_bad_entries
      $error("MAX_ENTRIES must be 1..2**CNT_W-1");
   end
   if ((1 << POS_W) <= DAT_W) begin : g_bad_pos
      $error("POS_W too narrow to reach an out-of-range msb");
   end
   if (DUMMY_READS < 1) begin : g_bad_dummy
      $error("DUMMY_READS must be at least 1");
   end

   logic             cfg_bad;
   logic [CNT_W-1:0] idx;
   logic [ADR_W-1:0] sel_adr;
   logic [DAT_W-1:0] sel_mask;
   logic [DAT_W-1:0] wr_data;
   logic [DAT_W-1:0] cap_q;

   trim_cfg_check #(
      .MAX_ENTRIES (MAX_ENTRIES),
      .CNT_W       (CNT_W),
      .POS_W       (POS_W),
      .DAT_W       (DAT_W)
   ) u_check (
      .entry_count (entry_count),
      .tbl_msb     (tbl_msb),
      .tbl_lsb     (tbl_lsb),
      .cfg_bad     (cfg_bad)
   );

   trim_entry_sel #(
      .MAX_ENTRIES    (MAX_ENTRIES),
      .CNT_W          (CNT_W),
      .ADR_W          (ADR_W),
      .POS_W          (POS_W),
      .DAT_W          (DAT_W),
      .MERGE_READBACK (MERGE_READBACK)
   ) u_sel (
      .idx      (idx),
      .tbl_adr  (tbl_adr),
      .tbl_msb  (tbl_msb),
      .tbl_lsb  (tbl_lsb),
      .tbl_val  (tbl_val),
      .readback (cap_q),
      .sel_adr  (sel_adr),
      .sel_mask (sel_mask),
      .wr_data  (wr_data)
   );

   trim_port_fsm #(
      .CNT_W       (CNT_W),
      .ADR_W       (ADR_W),
      .DAT_W       (DAT_W),
      .DUMMY_READS (DUMMY_READS)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .legacy_mode (legacy_mode),
      .entry_count (entry_count),
      .cfg_bad     (cfg_bad),
      .sel_adr     (sel_adr),
      .wr_data     (wr_data),
      .test_rdata  (test_rdata),
      .idx         (idx),
      .cap_q       (cap_q),
      .test_word   (test_word),
      .test_sample (test_sample),
      .busy        (busy),
      .done        (done),
      .cfg_err     (cfg_err)
   );

   if (MERGE_READBACK) begin : g_merge_chk
      // R6: outside the field, the written byte carries the captured read-back
      a_r6_neighbours_kept: assert property (@(posedge clk) disable iff (!rst_n)
         test_word[0] |-> ((test_word[WORD_W-1 -: DAT_W] & ~sel_mask) == (cap_q & ~sel_mask)));
   end

   // R1: the address field of the port word always names the selected entry
   a_r1_addr_field: assert property (@(posedge clk) disable iff (!rst_n)
      (test_word != '0) |-> (test_word[ADR_W:1] == sel_adr));

endmodule

// File: tb/trim_prog_seq_tb.sv
module trim_prog_seq_tb;

   localparam int NE = 7;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic        legacy_mode;
   logic [3:0]  entry_count;
   logic [NE*5-1:0] f_adr;
   logic [NE*4-1:0] f_msb;
   logic [NE*4-1:0] f_lsb;
   logic [NE*8-1:0] f_val;
   logic [13:0] test_word;
   logic [7:0]  test_rdata;
   logic        test_sample;
   logic        busy;
   logic        done;
   logic        cfg_err;

   logic [4:0] t_adr [NE];
   logic [3:0] t_msb [NE];
   logic [3:0] t_lsb [NE];
   logic [7:0] t_val [NE];

   always #10ns clk = ~clk;

   always_comb begin
      for (int i = 0; i < NE; i++) begin
         f_adr[i*5 +: 5] = t_adr[i];
         f_msb[i*4 +: 4] = t_msb[i];
         f_lsb[i*4 +: 4] = t_lsb[i];
         f_val[i*8 +: 8] = t_val[i];
      end
   end

   trim_prog_seq u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .legacy_mode (legacy_mode),
      .entry_count (entry_count),
      .tbl_adr     (f_adr),
      .tbl_msb     (f_msb),
      .tbl_lsb     (f_lsb),
      .tbl_val     (f_val),
      .test_word   (test_word),
      .test_rdata  (test_rdata),
      .test_sample (test_sample),
      .busy        (busy),
      .done        (done),
      .cfg_err     (cfg_err)
   );

   // PHY register-file model behind the test port
   logic [7:0] phy_mem [32];
   logic       init_req;

   function automatic logic [7:0] seed_val(int a);
      return 8'((a * 29 + 83) & 255);
   endfunction

   always @(posedge clk) begin
      if (init_req) begin
         for (int a = 0; a < 32; a++) phy_mem[a] <= seed_val(a);
      end else if (test_word[0]) begin
         phy_mem[test_word[5:1]] <= test_word[13:6];
      end
   end
   assign test_rdata = phy_mem[test_word[5:1]];

   // port monitor: records every newly presented word and counts protocol slips
   logic [13:0] rec [0:1023];
   int seg_n   = 0;
   int acc_n   = 0;
   int mon_err = 0;
   int smp_run = 0;
   logic [13:0] prev_word = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (test_word != '0 || test_sample) acc_n++;
         if (!busy && test_word != '0) mon_err++;
         if (test_word != '0 && !test_sample) begin
            if (seg_n > 0 && smp_run < 2) mon_err++;
            if (seg_n < 1024) rec[seg_n] = test_word;
            seg_n++;
            smp_run = 0;
         end
         if (test_sample) begin
            if (test_word != prev_word) mon_err++;
            smp_run++;
         end
         prev_word = test_word;
      end
   end

   int n_chk  = 0;
   int n_fail = 0;
   logic [7:0] exp_mem [32];

   task automatic check(input logic ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] fmask(int msb, int lsb);
      logic [7:0] m = '0;
      for (int b = 0; b < 8; b++) if (b >= lsb && b <= msb) m[b] = 1'b1;
      return m;
   endfunction

   task automatic run_case(input logic leg, input int cnt, input logic exp_err);
      int base_seg = seg_n;
      int base_acc = acc_n;
      int base_err = mon_err;
      int cyc = 0;
      int n_exp = 0;
      logic [13:0] ew [0:39];
      legacy_mode = leg;
      entry_count = 4'(cnt);
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check(busy && !done, "R9", "busy after start", {busy, done}, 2'b10);
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
      if (!exp_err && !leg) begin
         for (int i = 0; i < cnt; i++) begin
            int a = int'(t_adr[i]);
            logic [7:0] m = fmask(int'(t_msb[i]), int'(t_lsb[i]));
            logic [7:0] nv = (exp_mem[a] & ~m) | (8'(t_val[i] << t_lsb[i]) & m);
            logic [13:0] rdw = {8'd1, t_adr[i], 1'b0};
            logic [13:0] wrw = {nv, t_adr[i], 1'b0};
            ew[n_exp] = rdw; ew[n_exp+1] = wrw; ew[n_exp+2] = wrw | 14'd1;
            ew[n_exp+3] = wrw; ew[n_exp+4] = rdw;
            n_exp += 5;
            exp_mem[a] = nv;
         end
      end
      check(cfg_err == exp_err, "R10", "cfg_err", cfg_err, exp_err);
      check(cyc == 1 + 17 * n_exp / 5, (leg || exp_err || cnt == 0) ? "R8" : "R7",
            "start-to-done cycles", cyc, 1 + 17 * n_exp / 5);
      check(seg_n - base_seg == n_exp, "R3", "presented word count", seg_n - base_seg, n_exp);
      if (seg_n - base_seg == n_exp) begin
         for (int j = 0; j < n_exp; j++) begin
            string rq = (j % 5 == 0) ? "R3" : (j % 5 == 4) ? "R5" : "R4";
            check(rec[base_seg + j] == ew[j], rq, $sformatf("word %0d (R1 layout)", j),
                  rec[base_seg + j], ew[j]);
         end
      end
      check(mon_err == base_err, "R2", "settle/hold slips", mon_err - base_err, 0);
      if (n_exp == 0)
         check(acc_n == base_acc, "R8", "port cycles with no programming", acc_n - base_acc, 0);
      begin
         int bad = 0;
         int first = -1;
         for (int a = 0; a < 32; a++) begin
            if (phy_mem[a] !== exp_mem[a]) begin
               bad++;
               if (first < 0) first = a;
            end
         end
         check(bad == 0, "R6", $sformatf("PHY image (first bad reg %0d)", first),
               (first < 0) ? 0 : phy_mem[first], (first < 0) ? 0 : exp_mem[first]);
      end
   endtask

   task automatic set_ent(input int i, input int a, input int msb, input int lsb, input int v);
      t_adr[i] = 5'(a); t_msb[i] = 4'(msb); t_lsb[i] = 4'(lsb); t_val[i] = 8'(v);
   endtask

   initial begin
      #3ms;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; legacy_mode = 1'b0; entry_count = '0; init_req = 1'b1;
      for (int i = 0; i < NE; i++) set_ent(i, 0, 0, 0, 0);
      for (int a = 0; a < 32; a++) exp_mem[a] = seed_val(a);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(test_word == '0 && !test_sample && !busy && !done && !cfg_err, "R11",
            "reset outputs", {test_word, test_sample, busy, done, cfg_err}, 0);
      init_req = 1'b0;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(test_word == '0 && !done, "R11", "idle after reset", {test_word, done}, 0);

      // full seven-entry table
      set_ent(0, 7, 3, 0, 10);  set_ent(1, 8, 3, 0, 3);  set_ent(2, 9, 3, 0, 5);
      set_ent(3, 11, 3, 0, 9);  set_ent(4, 13, 6, 5, 2); set_ent(5, 27, 2, 0, 7);
      set_ent(6, 28, 1, 0, 1);
      run_case(1'b0, 7, 1'b0);

      // R9: done holds and the port stays quiet
      repeat (20) @(negedge clk);
      check(done && test_word == '0 && !test_sample, "R9", "done held while idle",
            {done, test_word}, 15'h4000);

      // R7: repeated register, index order decides the final image
      set_ent(0, 13, 7, 4, 9); set_ent(1, 13, 2, 1, 3); set_ent(2, 13, 4, 4, 1);
      set_ent(3, 4, 7, 0, 8'h5c);
      run_case(1'b0, 4, 1'b0);

      // R6 sweep over every legal field position
      for (int lo = 0; lo < 8; lo++) begin
         for (int hi = lo; hi < 8; hi++) begin
            set_ent(0, (lo * 8 + hi) % 32, hi, lo, 8'ha5 ^ (hi * 16 + lo));
            run_case(1'b0, 1, 1'b0);
         end
      end

      // R8: empty table and legacy mode
      run_case(1'b0, 0, 1'b0);
      set_ent(0, 3, 7, 0, 8'hff); set_ent(1, 5, 3, 2, 1); set_ent(2, 6, 0, 0, 0);
      run_case(1'b1, 3, 1'b0);

      // R10: configuration errors
      run_case(1'b0, 8, 1'b1);
      run_case(1'b0, 15, 1'b1);
      set_ent(1, 5, 9, 2, 1);
      run_case(1'b0, 3, 1'b1);
      run_case(1'b1, 3, 1'b1);
      set_ent(1, 5, 3, 2, 1); set_ent(2, 6, 1, 4, 3);
      run_case(1'b0, 3, 1'b1);
      // unused bad entry beyond the count is not judged
      set_ent(2, 6, 2, 0, 3); set_ent(5, 9, 12, 14, 0);
      run_case(1'b0, 2, 1'b0);
      check(!cfg_err && done, "R10", "error flag cleared by good run", cfg_err, 0);

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule